// File: doc/BRIEF.md
# Two-Master Shared Bus Arbiter

This block decides which of two masters drives a shared external bus: the on-chip master or one device outside the chip. Each side has a request, a grant and a busy line, all active-high and synchronous to one clock. A master requests the bus and waits for its grant. It then takes ownership by raising busy, but only once the busy line is seen low. Two arbitration modes exist. In the on-chip mode this block issues both grants. In the outside mode a central arbiter elsewhere issues the grant for the on-chip master, and this block's grant outputs stay low. A strap input picks the mode and is captured only while reset is asserted.

The block also contains the on-chip master's requester side. It converts a "want the bus" level into a request and takes ownership once granted and idle. It keeps ownership across an atomic sequence, such as a narrow-port split or a broken-up burst, for as long as a lock input stays high, even when the grant has been taken away. When the grant is withdrawn outside such a sequence, it drops busy and requests again before its next cycle.

Top module: `busarb_top`

## Requirements
- R1: While reset is held and for the first cycle after it, with all inputs low, int_bb, int_bg and ext_bg are all 0.
- R2: The mode strap cfg_ext_arb is captured only while rst_n is low (1 = outside arbiter, 0 = on-chip arbiter). Changing it after reset has no effect on grant behaviour.
- R3: In outside mode ext_bg stays 0, and int_bg follows ext_bg_in combinationally.
- R4: int_br equals int_want while int_bb is low, and is 0 while int_bb is high.
- R5: int_bb rises on the clock edge after a cycle in which int_want and int_bg are high and ext_bb is low. It never rises after a cycle with ext_bb high.
- R6: In on-chip mode, a lone request seen on an idle bus (int_bb and ext_bb low) is granted on the next edge, and ext_bg and the internal grant are never high together.
- R7: A grant is never newly issued on an edge where int_bb or ext_bb was high. It is issued on the first edge that samples both low.
- R8: When both requests are seen on an idle bus, the grant goes to the master that did not own the bus last. Here the owner is the master whose busy was last high. After reset the on-chip master wins.
- R9: While one master's busy is high and the other master requests, the owner's grant is removed on the next edge.
- R10: While int_lock is high, int_bb stays high once set, even without a grant. It falls on the edge after int_lock goes low if the grant is gone.
- R11: When the grant is lost and int_want stays high, int_bb falls, int_br rises again, and int_bb rises only after a fresh grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ext_arb | input | 1 | Mode strap, sampled during reset (1 = outside arbiter) |
| int_want | input | 1 | On-chip master wants the bus |
| int_lock | input | 1 | On-chip master is inside an atomic sequence |
| ext_br | input | 1 | Request from the external master |
| ext_bb | input | 1 | Busy from the external master |
| ext_bg_in | input | 1 | Grant for the on-chip master from an outside arbiter |
| int_br | output | 1 | On-chip master request |
| int_bb | output | 1 | On-chip master busy (owns the bus) |
| int_bg | output | 1 | Grant seen by the on-chip master |
| ext_bg | output | 1 | Grant to the external master from the on-chip arbiter |

## Verification
The assertions check on every cycle that the two grants never overlap and that neither grant appears after a busy cycle. They also check that the on-chip master only takes the bus after a granted, idle cycle, that a held lock keeps busy up, that an owner's grant is withdrawn when the other side requests, and that the strap stays fixed after reset. Only the bench scenarios can show which master wins a tie after a given history, that a post-reset strap change is ignored, the reset values, and the full lose-grant then re-request sequence. A sweep covers every request pair against both last-owner states.

// File: rtl/busarb_pkg.sv
// Package: shared types for the two-master bus arbiter.
// Assumes: exactly two masters, one on chip and one outside.
package busarb_pkg;
    typedef enum logic {
        OWN_INT = 1'b0,
        OWN_EXT = 1'b1
    } owner_e;

    typedef enum logic {
        ARB_ON_CHIP = 1'b0,
        ARB_OUTSIDE = 1'b1
    } arb_mode_e;

    typedef struct packed {
        logic gi;
        logic ge;
    } grant_t;
endpackage

// File: rtl/busarb_strap.sv
// Module: busarb_strap
// Captures the arbitration mode strap while reset is low and holds it after.
// Assumes: the strap is stable for at least one clock edge inside reset.
module busarb_strap
    import busarb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_ext,
    output arb_mode_e mode
);
    arb_mode_e mode_q;

    // Load the strap during reset; hold it once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= arb_mode_e'(cfg_ext);
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/busarb_core.sv
// Module: busarb_core
// Grant logic for one on-chip and one external master. Grants move only
// when the bus is idle. An owner's grant is withdrawn when the other side
// requests, and ties go to the master that did not own the bus last.
// Assumes: requests and busy lines are synchronous to clk.
module busarb_core
    import busarb_pkg::*;
#(
    parameter owner_e FIRST_WINNER = OWN_INT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic outside,
    input  logic req_int,
    input  logic req_ext,
    input  logic bb_int,
    input  logic bb_ext,
    output logic gnt_int,
    output logic gnt_ext
);
    localparam owner_e LAST_AT_RESET = (FIRST_WINNER == OWN_INT) ? OWN_EXT : OWN_INT;

    grant_t cur_q;
    grant_t nxt;
    owner_e last_q;
    logic   bus_busy;

    assign bus_busy = bb_int | bb_ext;

    // Choose next grant pair from mode, busy state, requests and history.
    always_comb begin
        nxt = cur_q;
        if (outside) begin
            nxt.gi = 1'b0;
            nxt.ge = 1'b0;
        end else if (bus_busy) begin
            nxt.gi = cur_q.gi & ~req_ext;
            nxt.ge = cur_q.ge & ~req_int;
        end else begin
            unique case ({req_int, req_ext})
                2'b11: begin
                    nxt.gi = (last_q == OWN_EXT);
                    nxt.ge = (last_q == OWN_INT);
                end
                2'b10: begin
                    nxt.gi = 1'b1;
                    nxt.ge = 1'b0;
                end
                2'b01: begin
                    nxt.gi = 1'b0;
                    nxt.ge = 1'b1;
                end
                default: begin
                    nxt.gi = 1'b0;
                    nxt.ge = 1'b0;
                end
            endcase
        end
    end

    // Register the grant pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.gi <= 1'b0;
            cur_q.ge <= 1'b0;
        end else begin
            cur_q <= nxt;
        end
    end

    // Remember which master last drove busy, for tie breaking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= LAST_AT_RESET;
        end else if (bb_int) begin
            last_q <= OWN_INT;
        end else if (bb_ext) begin
            last_q <= OWN_EXT;
        end
    end

    assign gnt_int = cur_q.gi;
    assign gnt_ext = cur_q.ge;
endmodule

// File: rtl/busarb_requester.sv
// Module: busarb_requester
// On-chip master's request/ownership side. Requests while it wants the bus
// and does not own it. Takes busy once granted and the other busy is low.
// Keeps busy through an atomic lock even without a grant.
// Assumes: want and lock are driven by the on-chip master, synchronous to clk.
module busarb_requester (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic lock,
    input  logic gnt,
    input  logic bb_other,
    output logic br,
    output logic bb
);
    logic bb_q;
    logic bb_n;

    // Decide whether ownership starts, continues or ends.
    always_comb begin
        if (!bb_q) begin
            bb_n = want & gnt & ~bb_other;
        end else begin
            bb_n = (want & gnt) | lock;
        end
    end

    // Register ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bb_q <= 1'b0;
        end else begin
            bb_q <= bb_n;
        end
    end

    assign br = want & ~bb_q;
    assign bb = bb_q;
endmodule

// File: rtl/busarb_top.sv
// Module: busarb_top
// Two-master shared bus arbiter with mode strap and on-chip requester.
// Assumes: the external master obeys the same request/grant/busy protocol.
module busarb_top
    import busarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_ext_arb,
    input  logic int_want,
    input  logic int_lock,
    input  logic ext_br,
    input  logic ext_bb,
    input  logic ext_bg_in,
    output logic int_br,
    output logic int_bb,
    output logic int_bg,
    output logic ext_bg
);
    arb_mode_e mode;
    logic      mode_outside;
    logic      arb_gi;
    logic      arb_ge;
    logic      req_int;
    logic      bb_int;
    logic      gnt_sel;

    busarb_strap strap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_ext (cfg_ext_arb),
        .mode    (mode)
    );

    assign mode_outside = (mode == ARB_OUTSIDE);

    busarb_core #(
        .FIRST_WINNER (OWN_INT)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .outside (mode_outside),
        .req_int (req_int),
        .req_ext (ext_br),
        .bb_int  (bb_int),
        .bb_ext  (ext_bb),
        .gnt_int (arb_gi),
        .gnt_ext (arb_ge)
    );

    // Grant seen by the on-chip requester depends on the strapped mode.
    assign gnt_sel = mode_outside ? ext_bg_in : arb_gi;

    busarb_requester req_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (int_want),
        .lock     (int_lock),
        .gnt      (gnt_sel),
        .bb_other (ext_bb),
        .br       (req_int),
        .bb       (bb_int)
    );

    assign int_br = req_int;
    assign int_bb = bb_int;
    assign int_bg = gnt_sel;
    assign ext_bg = arb_ge;
endmodule

// File: rtl/busarb_checker.sv
// Module: busarb_checker
// Protocol properties for busarb_top, attached by bind.
module busarb_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_outside,
    input logic arb_gi,
    input logic int_lock,
    input logic int_bb,
    input logic int_bg,
    input logic ext_bb,
    input logic ext_br,
    input logic ext_bg
);
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_outside));

    p_outside_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_outside |-> (!ext_bg && !arb_gi));

    p_take_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_bb) |-> $past(int_bg && !ext_bb));

    p_grant_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(arb_gi && ext_bg));

    p_ext_grant_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_bg) |-> $past(!int_bb && !ext_bb));

    p_int_grant_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_gi) |-> $past(!int_bb && !ext_bb));

    p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_gi && int_bb && ext_br && !mode_outside) |=> !arb_gi);

    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_bb && int_lock) |=> int_bb);
endmodule

bind busarb_top busarb_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_outside (mode_outside),
    .arb_gi       (arb_gi),
    .int_lock     (int_lock),
    .int_bb       (int_bb),
    .int_bg       (int_bg),
    .ext_bb       (ext_bb),
    .ext_br       (ext_br),
    .ext_bg       (ext_bg)
);

// File: tb/busarb_top_tb_top.sv
// Bench: directed scenarios plus a sweep of tie/lone requests against both
// last-owner states, with expected grants computed arithmetically.
module busarb_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ext_arb = 1'b0;
    logic int_want = 1'b0;
    logic int_lock = 1'b0;
    logic ext_br = 1'b0;
    logic ext_bb = 1'b0;
    logic ext_bg_in = 1'b0;
    logic int_br, int_bb, int_bg, ext_bg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    busarb_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_ext_arb (cfg_ext_arb),
        .int_want    (int_want),
        .int_lock    (int_lock),
        .ext_br      (ext_br),
        .ext_bb      (ext_bb),
        .ext_bg_in   (ext_bg_in),
        .int_br      (int_br),
        .int_bb      (int_bb),
        .int_bg      (int_bg),
        .ext_bg      (ext_bg)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        cfg_ext_arb = strap;
        int_want = 0; int_lock = 0; ext_br = 0; ext_bb = 0; ext_bg_in = 0;
        repeat (3) tick();
        chk("R1 int_bb in reset", int_bb, 1'b0);
        chk("R1 int_bg in reset", int_bg, 1'b0);
        chk("R1 ext_bg in reset", ext_bg, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 int_bb after reset", int_bb, 1'b0);
        chk("R1 ext_bg after reset", ext_bg, 1'b0);
        cfg_ext_arb = ~strap;
    endtask

    // One sweep point: requests (ri, re) on an idle bus, last owner = last_ext.
    task automatic sweep_point(input logic ri, input logic re, input logic last_ext);
        logic exp_gi, exp_ge;
        int_want = ri;
        ext_br = re;
        tick();
        exp_gi = ri & (~re | last_ext);
        exp_ge = re & (~ri | ~last_ext);
        chk("R8 sweep int grant", int_bg, exp_gi);
        chk("R8 sweep ext grant", ext_bg, exp_ge);
        int_want = 0;
        ext_br = 0;
        tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // On-chip mode; strap flipped to 1 right after reset (R2).
        do_reset(1'b0);

        int_want = 1;
        #1;
        chk("R4 request follows want", int_br, 1'b1);
        tick();
        chk("R6 lone request granted", int_bg, 1'b1);
        chk("R6 other grant low", ext_bg, 1'b0);
        chk("R5 not yet busy", int_bb, 1'b0);
        tick();
        chk("R5 busy after grant and idle", int_bb, 1'b1);
        chk("R4 request drops while busy", int_br, 1'b0);

        // Locked sequence while the external master requests.
        int_lock = 1;
        ext_br = 1;
        tick();
        chk("R9 owner grant withdrawn", int_bg, 1'b0);
        chk("R7 no ext grant while busy", ext_bg, 1'b0);
        chk("R10 busy held by lock", int_bb, 1'b1);
        tick();
        chk("R10 busy still held", int_bb, 1'b1);
        chk("R7 ext grant still held off", ext_bg, 1'b0);
        int_lock = 0;
        tick();
        chk("R10 busy falls after lock", int_bb, 1'b0);
        chk("R7 no grant on busy edge", ext_bg, 1'b0);
        chk("R11 request reasserted", int_br, 1'b1);
        tick();
        chk("R8 tie goes to non-last owner", ext_bg, 1'b1);
        chk("R2 strap change ignored", int_bg, 1'b0);

        // External master takes the bus; on-chip master keeps requesting.
        ext_bb = 1;
        ext_br = 0;
        tick();
        chk("R9 ext grant withdrawn", ext_bg, 1'b0);
        chk("R5 no take while ext busy", int_bb, 1'b0);
        tick();
        chk("R7 no int grant while ext busy", int_bg, 1'b0);
        ext_bb = 0;
        tick();
        chk("R7 grant on first idle edge", int_bg, 1'b1);
        tick();
        chk("R11 busy after fresh grant", int_bb, 1'b1);
        int_want = 0;
        tick();
        chk("R11 busy released without want", int_bb, 1'b0);
        tick();
        tick();

        // Sweep: after reset the on-chip side wins ties (last owner = ext).
        do_reset(1'b0);
        for (int k = 0; k < 4; k++) sweep_point(k[1], k[0], 1'b1);
        // Make the on-chip master the last owner, then sweep again.
        int_want = 1;
        tick();
        tick();
        chk("R5 ownership for sweep", int_bb, 1'b1);
        int_want = 0;
        repeat (3) tick();
        for (int k = 0; k < 4; k++) sweep_point(k[1], k[0], 1'b0);

        // Outside mode; strap flipped to 0 after reset (R2).
        do_reset(1'b1);
        int_want = 1;
        ext_br = 1;
        tick();
        tick();
        chk("R3 ext_bg quiet outside", ext_bg, 1'b0);
        chk("R3 int_bg low without outside grant", int_bg, 1'b0);
        chk("R2 strap held outside", int_bb, 1'b0);
        ext_bg_in = 1;
        ext_bb = 1;
        #1;
        chk("R3 int_bg follows outside grant", int_bg, 1'b1);
        tick();
        chk("R5 no take while ext busy", int_bb, 1'b0);
        ext_bb = 0;
        tick();
        chk("R5 take after idle", int_bb, 1'b1);
        ext_bg_in = 0;
        tick();
        chk("R11 busy dropped on lost grant", int_bb, 1'b0);
        chk("R11 request again", int_br, 1'b1);
        ext_bg_in = 1;
        int_lock = 1;
        tick();
        chk("R11 busy after regrant", int_bb, 1'b1);
        ext_bg_in = 0;
        tick();
        chk("R10 lock holds busy outside", int_bb, 1'b1);
        chk("R3 ext_bg still quiet", ext_bg, 1'b0);
        int_lock = 0;
        tick();
        chk("R10 busy falls after lock", int_bb, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule